// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sequences the power states of a processor core on behalf of system hardware. The system requests low power by driving an active-low, asynchronous stop request. The controller first has the bus unit run a stop-grant bus cycle through a request/done handshake. Once that cycle completes, it drops the core clock enable, and the core sits in the Stop Grant state. When the system lets go of the request, the controller turns the core clock back on.

While the core clock is gated, the system may also stop the input clock altogether. The controller watches an input-clock activity indication. When activity disappears, it records the deeper Stop Clock state. When activity returns, it does not go straight back. It first waits in a relock stage until the input clock has run without a break for a parameterised number of always-on reference clock cycles. The default is one millisecond at 100 MHz, which lets the PLL settle. Only then does it return to Stop Grant. Both asynchronous inputs pass through a synchronizer before the state machine acts on them.

Top module: `clkstop_ctrl`

## Requirements
- R1: The state output uses the codes RUN=0, GRANT_CYCLE=1, STOP_GRANT=2, STOP_CLOCK=3 and RELOCK=4. After reset the state is RUN, core_clk_en is 1 and stop_cyc_req is 0.
- R2: stop_req_n is active low. It passes through SYNC_STAGES reference-clock flops that reset to the inactive level (1), so an undriven or idle pin never starts a sequence. A low level that is set up before reference edge k moves RUN to GRANT_CYCLE at edge k+SYNC_STAGES, and not earlier.
- R3: core_clk_en is 1 in RUN and GRANT_CYCLE and 0 in STOP_GRANT, STOP_CLOCK and RELOCK.
- R4: stop_cyc_req is 1 exactly while the state is GRANT_CYCLE. It stays high until cyc_done is sampled at 1, and the state becomes STOP_GRANT on that edge.
- R5: Releasing the request during GRANT_CYCLE does not abandon the bus cycle. The state stays in GRANT_CYCLE until cyc_done and then enters STOP_GRANT.
- R6: In STOP_GRANT, with the input clock active, a synchronized release of the request returns the state to RUN on the next reference edge, and core_clk_en returns to 1 at the same edge.
- R7: In STOP_GRANT, a synchronized loss of input-clock activity moves the state to STOP_CLOCK on the next edge. This takes priority over a release of the request.
- R8: STOP_CLOCK holds while activity is absent, whatever the request does. The first synchronized active sample moves the state to RELOCK.
- R9: RELOCK lasts exactly RELOCK_CYCLES reference cycles of uninterrupted activity and then enters STOP_GRANT.
- R10: A synchronized loss of activity during RELOCK keeps the state in RELOCK and restarts the relock count from zero.
- R11: cyc_done has no effect outside GRANT_CYCLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| cyc_done | input | 1 | Bus unit reports that the stop-grant cycle is finished |
| in_clk_alive | input | 1 | Asynchronous indication that the input clock is running |
| stop_cyc_req | output | 1 | Asks the bus unit to run a stop-grant cycle |
| core_clk_en | output | 1 | Enable for the core clock gate |
| pm_state | output | 3 | Current power state code |

## Verification
On every cycle, the embedded assertions check the local transitions:
- RUN to GRANT_CYCLE on a synchronized request;
- GRANT_CYCLE to STOP_GRANT on cyc_done;
- the release and clock-loss exits from STOP_GRANT;
- the STOP_CLOCK hold;
- the relock counter stepping and restarting.

Other properties need chosen stimulus sequences, so only the bench's scenarios can show them:
- the exact synchronizer latency from the pin;
- that a release during the bus cycle is ignored;
- the full relock duration;
- that a one-cycle activity dropout stretches RELOCK.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    PM_RUN         = 3'd0,
    PM_GRANT_CYCLE = 3'd1,
    PM_STOP_GRANT  = 3'd2,
    PM_STOP_CLOCK  = 3'd3,
    PM_RELOCK      = 3'd4
  } pm_state_e;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_async;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[LAST];

endmodule

// File: rtl/clkstop_relock_timer.sv
module clkstop_relock_timer #(
  parameter int RELOCK_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic alive,
  output logic expired
);

  localparam int                CNT_W = (RELOCK_CYCLES > 1) ? $clog2(RELOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(RELOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = run_en && alive && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_en || !alive || expired) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_restart_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !alive) |=> (cnt_q == '0));

  assert_count_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && alive && !expired) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
  import clkstop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_act,
  input  logic      alive,
  input  logic      cyc_done,
  input  logic      relock_done,
  output pm_state_e state,
  output logic      relock_run,
  output logic      cyc_req,
  output logic      clk_en
);

  pm_state_e state_q;
  pm_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:         if (req_act)     state_d = PM_GRANT_CYCLE;
      PM_GRANT_CYCLE: if (cyc_done)    state_d = PM_STOP_GRANT;
      PM_STOP_GRANT: begin
        if (!alive)        state_d = PM_STOP_CLOCK;
        else if (!req_act) state_d = PM_RUN;
      end
      PM_STOP_CLOCK:  if (alive)       state_d = PM_RELOCK;
      PM_RELOCK:      if (relock_done) state_d = PM_STOP_GRANT;
      default:                         state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign relock_run = (state_q == PM_RELOCK);
  assign cyc_req    = (state_q == PM_GRANT_CYCLE);
  assign clk_en     = (state_q == PM_RUN) || (state_q == PM_GRANT_CYCLE);

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {PM_RUN, PM_GRANT_CYCLE, PM_STOP_GRANT, PM_STOP_CLOCK, PM_RELOCK}));

  assert_request_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && req_act) |=> (state_q == PM_GRANT_CYCLE && cyc_req));

  assert_clk_en_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> ($past(state_q) == PM_STOP_GRANT));

  assert_done_grants_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_GRANT_CYCLE && cyc_done) |=> (state_q == PM_STOP_GRANT && !clk_en));

  assert_cycle_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_GRANT_CYCLE && !cyc_done) |=> (state_q == PM_GRANT_CYCLE));

  assert_release_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP_GRANT && alive && !req_act) |=> (state_q == PM_RUN && clk_en));

  assert_loss_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP_GRANT && !alive) |=> (state_q == PM_STOP_CLOCK));

  assert_stop_clock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP_CLOCK && !alive) |=> (state_q == PM_STOP_CLOCK));

  assert_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !req_act && cyc_done) |=> (state_q == PM_RUN));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int RELOCK_CYCLES = 100000
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       stop_req_n,
  input  logic       cyc_done,
  input  logic       in_clk_alive,
  output logic       stop_cyc_req,
  output logic       core_clk_en,
  output logic [2:0] pm_state
);

  logic      req_n_s;
  logic      alive_s;
  logic      relock_run;
  logic      relock_done;
  pm_state_e state;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .d_async (stop_req_n),
    .q_sync  (req_n_s)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_alive_sync (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .d_async (in_clk_alive),
    .q_sync  (alive_s)
  );

  clkstop_relock_timer #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_timer (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .run_en  (relock_run),
    .alive   (alive_s),
    .expired (relock_done)
  );

  clkstop_fsm u_fsm (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .req_act     (~req_n_s),
    .alive       (alive_s),
    .cyc_done    (cyc_done),
    .relock_done (relock_done),
    .state       (state),
    .relock_run  (relock_run),
    .cyc_req     (stop_cyc_req),
    .clk_en      (core_clk_en)
  );

  assign pm_state = state;

  assert_relock_exit_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (relock_done) |=> (pm_state == 3'd2));

endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;

  localparam int SYNC = 2;
  localparam int NREL = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop_req_n;
  logic       cyc_done;
  logic       in_clk_alive;
  logic       stop_cyc_req;
  logic       core_clk_en;
  logic [2:0] pm_state;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  clkstop_ctrl #(.SYNC_STAGES(SYNC), .RELOCK_CYCLES(NREL)) u_dut (
    .ref_clk      (clk),
    .rst_n        (rst_n),
    .stop_req_n   (stop_req_n),
    .cyc_done     (cyc_done),
    .in_clk_alive (in_clk_alive),
    .stop_cyc_req (stop_cyc_req),
    .core_clk_en  (core_clk_en),
    .pm_state     (pm_state)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // Behavioural reference model: delay lines for the two async inputs
  int mstate;
  int mcnt;
  bit req_line[$];
  bit alive_line[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstate = 0;
      mcnt   = 0;
      req_line.delete();
      alive_line.delete();
      for (int i = 0; i < SYNC; i++) begin
        req_line.push_back(1'b1);
        alive_line.push_back(1'b1);
      end
    end else begin
      bit ract;
      bit alv;
      cyc++;
      ract = !req_line[0];
      alv  = alive_line[0];
      case (mstate)
        0: if (ract) mstate = 1;
        1: if (cyc_done) mstate = 2;
        2: if (!alv) mstate = 3; else if (!ract) mstate = 0;
        3: if (alv) begin mstate = 4; mcnt = 0; end
        4: begin
          if (!alv) mcnt = 0;
          else if (mcnt == NREL - 1) begin mstate = 2; mcnt = 0; end
          else mcnt++;
        end
        default: mstate = 0;
      endcase
      void'(req_line.pop_front());
      void'(alive_line.pop_front());
      req_line.push_back(stop_req_n);
      alive_line.push_back(in_clk_alive);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 model state", int'(pm_state), mstate);
      chk("R3 model clk_en", int'(core_clk_en), int'(mstate <= 1));
      chk("R4 model cyc_req", int'(stop_cyc_req), int'(mstate == 1));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_done_pulse();
    #1 cyc_done = 1'b1;
    @(negedge clk);
    #1 cyc_done = 1'b0;
  endtask

  initial begin
    int t;
    rst_n = 1'b0; stop_req_n = 1'b1; cyc_done = 1'b0; in_clk_alive = 1'b1;
    tick(3);
    #1 rst_n = 1'b1;
    tick(1);
    chk("R1 reset state", int'(pm_state), 0);
    chk("R1 reset clk_en", int'(core_clk_en), 1);
    chk("R1 reset cyc_req", int'(stop_cyc_req), 0);

    // R11: cyc_done while idle
    drive_done_pulse();
    tick(1);
    chk("R11 done ignored in RUN", int'(pm_state), 0);

    // R2: request latency
    #1 stop_req_n = 1'b0;
    tick(SYNC);
    chk("R2 no early start", int'(pm_state), 0);
    tick(1);
    chk("R2 start grant cycle", int'(pm_state), 1);
    chk("R3 clk on in grant cycle", int'(core_clk_en), 1);
    tick(4);
    chk("R4 cyc_req held", int'(stop_cyc_req), 1);
    drive_done_pulse();
    chk("R4 stop grant after done", int'(pm_state), 2);
    chk("R3 clk gated", int'(core_clk_en), 0);
    chk("R4 cyc_req dropped", int'(stop_cyc_req), 0);

    // R6: release
    #1 stop_req_n = 1'b1;
    tick(SYNC);
    chk("R6 still stop grant", int'(pm_state), 2);
    tick(1);
    chk("R6 back to run", int'(pm_state), 0);
    chk("R6 clk on", int'(core_clk_en), 1);

    // R5: release during grant cycle
    #1 stop_req_n = 1'b0;
    tick(SYNC + 1);
    chk("R5 in grant cycle", int'(pm_state), 1);
    #1 stop_req_n = 1'b1;
    tick(5);
    chk("R5 release ignored", int'(pm_state), 1);
    drive_done_pulse();
    chk("R5 cycle completed", int'(pm_state), 2);
    tick(1);
    chk("R5 then run", int'(pm_state), 0);

    // R7: clock loss in stop grant, with simultaneous release
    #1 stop_req_n = 1'b0;
    tick(SYNC + 1);
    drive_done_pulse();
    chk("R7 stop grant", int'(pm_state), 2);
    #1 begin in_clk_alive = 1'b0; stop_req_n = 1'b1; end
    tick(SYNC);
    chk("R7 still stop grant", int'(pm_state), 2);
    tick(1);
    chk("R7 stop clock wins", int'(pm_state), 3);

    // R8: hold regardless of request
    tick(6);
    chk("R8 stop clock holds", int'(pm_state), 3);
    #1 stop_req_n = 1'b0;
    tick(4);
    chk("R8 stop clock holds with request", int'(pm_state), 3);

    // R9: relock duration
    #1 in_clk_alive = 1'b1;
    tick(SYNC);
    chk("R9 not yet relock", int'(pm_state), 3);
    tick(1);
    chk("R9 relock entered", int'(pm_state), 4);
    tick(NREL - 1);
    chk("R9 relock last cycle", int'(pm_state), 4);
    tick(1);
    chk("R9 stop grant after relock", int'(pm_state), 2);

    // R10: dropout during relock
    #1 in_clk_alive = 1'b0;
    tick(SYNC + 1);
    chk("R10 stop clock", int'(pm_state), 3);
    #1 in_clk_alive = 1'b1;
    tick(SYNC + 1);
    chk("R10 relock entered", int'(pm_state), 4);
    tick(2);
    #1 in_clk_alive = 1'b0;
    tick(1);
    #1 in_clk_alive = 1'b1;
    tick(NREL - 1);
    chk("R10 relock stretched", int'(pm_state), 4);
    t = 0;
    while (pm_state == 3'd4 && t < 50) begin tick(1); t++; end
    chk("R10 relock finished", int'(pm_state), 2);

    // Release and return
    #1 stop_req_n = 1'b1;
    tick(SYNC + 1);
    chk("R6 final run", int'(pm_state), 0);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", wd);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule